// File: doc/BRIEF.md
# Triggered Delayed One-Shot Pulse Generator

This block turns each rising edge on an asynchronous trigger pin into a single output pulse. The edge passes through a synchronizer and then restarts an internal up-counter from zero. The counter advances once per tick, and a tick is the system clock divided by a fixed ratio. The output goes high when the counter reaches the set-point value and goes low when it reaches the stop-point value. The stop-point match also halts the counter, so each trigger edge produces exactly one pulse.

The set-point alone fixes the delay from the edge to the pulse. The distance between the two compare values alone fixes the pulse width. A trigger edge that arrives while a pulse is still in progress restarts the sequence. The block needs no service between triggers, which suits periodic trigger rates that are too fast for software to follow. Every pin is a plain control or level signal. Nothing flows through the block as data, so it has no valid/ready handshake and applies no back-pressure.

Top module: `dly_pulse_gen`

## Requirements
- R1: While reset is asserted and after it is released, `pulse_out` is low and stays low until a trigger edge is accepted.
- R2: While `enable` is low, trigger edges are ignored, and `pulse_out` is low from the clock edge after `enable` is sampled low.
- R3: The trigger passes through two synchronizer flops and an edge detector. For a rise first sampled at clock edge k, the counter restarts at edge k+2. Falling edges of the trigger have no effect.
- R4: After a restart, the counter advances by one every 2 system clocks. The first increment lands at edge k+4.
- R5: With `cmp_a` < `cmp_c`, `pulse_out` is first high after edge k+2+2*`cmp_a`. When `cmp_a` is 0, this is the restart edge k+2 itself.
- R6: `pulse_out` is low from edge k+2+2*`cmp_c`, and the counter stops there. No further pulse appears without a new rising edge.
- R7: When `cmp_a` >= `cmp_c`, `pulse_out` never goes high. A stop-point of 0 stops the counter at the restart edge itself.
- R8: A rising edge that arrives during a pulse restarts the counter from zero. `pulse_out` keeps its current level until the next compare action.
- R9: With `cmp_a` = 1 and `cmp_c` = 2, the pulse starts 4 clocks after the trigger is first sampled and lasts exactly one tick (2 clocks).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Channel enable; low holds the channel idle with the output low |
| trig_in | input | 1 | Asynchronous trigger; a rising edge starts a sequence |
| cmp_a | input | CNT_W | Set-point: the count at which the output rises |
| cmp_c | input | CNT_W | Stop-point: the count at which the output falls and counting stops |
| pulse_out | output | 1 | One-shot pulse output |

## Verification
The assertions assume that `cmp_a` and `cmp_c` stay stable while the counter runs. They also assume the compare values do not change in the same cycle that a restart is accepted. The stimulus therefore loads new compare values only while the channel is stopped, and waits two idle clocks before it raises the trigger. Trigger pulses are held high for at least one clock and low for at least two clocks before a new rise, so the synchronizer sees every edge the bench intends.

// File: rtl/dly_pulse_gen_pkg.sv
package dly_pulse_gen_pkg;

  // Action chosen for the output on a counter step
  typedef enum logic [1:0] {
    CMP_HOLD  = 2'd0,
    CMP_SET   = 2'd1,
    CMP_CLEAR = 2'd2
  } cmp_act_e;

endpackage

// File: rtl/dly_sync_edge.sv
module dly_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic rise
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= d_async;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_async};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[STAGES-1];
  end

  // Only a low-to-high transition of the synchronized level counts
  assign rise = chain_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/dly_tick_div.sv
module dly_tick_div #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic tick
);

  localparam int PC_W = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV == 1) begin : g_nodiv
      assign tick = run & ~clear;
    end else begin : g_div
      localparam logic [PC_W-1:0] PC_LAST = PC_W'(DIV - 1);
      logic [PC_W-1:0] pc_q;

      assign tick = run & ~clear & (pc_q == PC_LAST);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            pc_q <= '0;
        else if (clear || !run) pc_q <= '0;
        else if (tick)         pc_q <= '0;
        else                   pc_q <= pc_q + 1'b1;
      end
    end
  endgenerate

endmodule

// File: rtl/dly_chan_core.sv
module dly_chan_core
  import dly_pulse_gen_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             restart,
  input  logic             tick,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [CNT_W-1:0] cmp_c,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic             level
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;
  logic             run_q;
  logic             lvl_q;
  cmp_act_e         step_act;
  logic             zero_stop;
  logic             zero_set;

  // Compare against the value the counter takes on this tick; stop wins over set
  always_comb begin
    cnt_inc  = cnt_q + 1'b1;
    step_act = CMP_HOLD;
    if (cnt_inc == cmp_c)      step_act = CMP_CLEAR;
    else if (cnt_inc == cmp_a) step_act = CMP_SET;
  end

  // Compares applied to count zero at the restart edge
  assign zero_stop = (cmp_c == '0);
  assign zero_set  = (cmp_a == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      lvl_q <= 1'b0;
    end else if (!enable) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      lvl_q <= 1'b0;
    end else if (restart) begin
      cnt_q <= '0;
      if (zero_stop) begin
        run_q <= 1'b0;
        lvl_q <= 1'b0;
      end else begin
        run_q <= 1'b1;
        if (zero_set) lvl_q <= 1'b1;
      end
    end else if (run_q && tick) begin
      cnt_q <= cnt_inc;
      unique case (step_act)
        CMP_CLEAR: begin
          run_q <= 1'b0;
          lvl_q <= 1'b0;
        end
        CMP_SET:   lvl_q <= 1'b1;
        default:   ;
      endcase
    end
  end

  assign count   = cnt_q;
  assign running = run_q;
  assign level   = lvl_q;

endmodule

// File: rtl/dly_pulse_gen.sv
module dly_pulse_gen
  import dly_pulse_gen_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int TICK_DIV    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             trig_in,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [CNT_W-1:0] cmp_c,
  output logic             pulse_out
);

  logic             trig_rise;
  logic             restart;
  logic             tick;
  logic             running;
  logic [CNT_W-1:0] count;
  logic             div_clear;

  dly_sync_edge #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (trig_in),
    .rise    (trig_rise)
  );

  assign restart   = trig_rise & enable;
  assign div_clear = restart | ~enable;

  dly_tick_div #(
    .DIV (TICK_DIV)
  ) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (div_clear),
    .run   (running),
    .tick  (tick)
  );

  dly_chan_core #(
    .CNT_W (CNT_W)
  ) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .restart (restart),
    .tick    (tick),
    .cmp_a   (cmp_a),
    .cmp_c   (cmp_c),
    .count   (count),
    .running (running),
    .level   (pulse_out)
  );

endmodule

// File: rtl/dly_pulse_gen_chk.sv
module dly_pulse_gen_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         enable,
  input logic         restart,
  input logic         tick,
  input logic         running,
  input logic [W-1:0] count,
  input logic [W-1:0] cmp_a,
  input logic [W-1:0] cmp_c,
  input logic         pulse_out
);

  logic [W-1:0] step_val;
  assign step_val = count + 1'b1;

  assert_idle_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!pulse_out && !running));

  assert_hold_between_ticks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && running && !tick && !restart) |=> $stable(count));

  assert_stop_at_c_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && running && tick && !restart && step_val == cmp_c) |=> (!running && !pulse_out));

  assert_count_below_c_R6: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (count < cmp_c));

  assert_rise_has_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_out) |-> $past(enable && (restart || (running && tick))));

  assert_never_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_a >= cmp_c && !pulse_out && !restart) |=> !pulse_out);

endmodule

bind dly_pulse_gen dly_pulse_gen_chk #(.W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .restart   (restart),
  .tick      (tick),
  .running   (running),
  .count     (count),
  .cmp_a     (cmp_a),
  .cmp_c     (cmp_c),
  .pulse_out (pulse_out)
);

// File: tb/dly_pulse_gen_bench.sv
`timescale 1ns/1ps
module dly_pulse_gen_bench;

  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             enable = 1'b0;
  logic             trig_in = 1'b0;
  logic [CNT_W-1:0] cmp_a = '0;
  logic [CNT_W-1:0] cmp_c = '0;
  logic             pulse_out;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dly_pulse_gen #(.CNT_W(CNT_W)) u_dly_pulse_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .trig_in   (trig_in),
    .cmp_a     (cmp_a),
    .cmp_c     (cmp_c),
    .pulse_out (pulse_out)
  );

  task automatic check(input string req, input int n, input bit got, input bit want);
    n_vec++;
    if (got !== want) begin
      n_bad++;
      $display("FAIL %s n=%0d actual=%0b expected=%0b", req, n, got, want);
    end
  endtask

  // Single trigger first sampled at edge 0: output level after edge n
  function automatic bit exp_one(input int n, input int a, input int c);
    return (a < c) && (n >= 2 + 2*a) && (n < 2 + 2*c);
  endfunction

  // Second rise first sampled at edge d (retrigger case)
  function automatic bit exp_re(input int n, input int a, input int c, input int d);
    int n2;
    n2 = n - d;
    if (n2 < 2) return exp_one(n, a, c);
    if (c == 0 || n2 >= 2 + 2*c) return 1'b0;
    if (a < c && n2 >= 2 + 2*a) return 1'b1;
    return exp_one(d + 1, a, c);
  endfunction

  task automatic fire(input string req, input int a, input int c, input int h,
                      input bit re, input int d);
    int last;
    bit want;
    @(negedge clk);
    cmp_a = CNT_W'(a);
    cmp_c = CNT_W'(c);
    @(negedge clk);
    @(negedge clk);
    last = (re ? d : 0) + 2 + 2*c + 4;
    trig_in = 1'b1;
    for (int n = 0; n <= last; n++) begin
      @(posedge clk);
      @(negedge clk);
      want = re ? exp_re(n, a, c, d) : exp_one(n, a, c);
      check(req, n, pulse_out, want);
      if (n + 1 == h) trig_in = 1'b0;
      if (re && n + 1 == d) trig_in = 1'b1;
      if (re && n + 1 == d + h) trig_in = 1'b0;
    end
    trig_in = 1'b0;
  endtask

  initial begin
    #(20.0 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: output low in and after reset
    repeat (3) @(negedge clk);
    check("R1", 0, pulse_out, 1'b0);
    rst_n = 1'b1;
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      check("R1", i, pulse_out, 1'b0);
    end
    enable = 1'b1;

    // R9: the canonical one-tick pulse one tick after the trigger
    fire("R9", 1, 2, 1, 1'b0, 0);
    // R3 and R5: zero set-point rises on the restart edge itself
    fire("R3", 0, 3, 2, 1'b0, 0);
    // R3: falling trigger edge during the pulse is ignored
    fire("R3", 1, 8, 9, 1'b0, 0);
    // R7: set-point not below stop-point
    fire("R7", 5, 5, 1, 1'b0, 0);
    fire("R7", 7, 3, 1, 1'b0, 0);
    fire("R7", 0, 0, 1, 1'b0, 0);
    // R8: retrigger while high, and while waiting for the set-point
    fire("R8", 2, 9, 1, 1'b1, 10);
    fire("R8", 4, 6, 2, 1'b1, 6);
    // R6: long pulse ends exactly at the stop-point
    fire("R6", 3, 12, 3, 1'b0, 0);

    // R2: dropping enable during a pulse clears the output one edge later
    @(negedge clk);
    cmp_a = 16'd2;
    cmp_c = 16'd8;
    @(negedge clk);
    @(negedge clk);
    trig_in = 1'b1;
    for (int n = 0; n <= 7; n++) begin
      @(posedge clk);
      @(negedge clk);
      if (n == 0) trig_in = 1'b0;
      if (n == 6) begin
        check("R2", n, pulse_out, 1'b1);
        enable = 1'b0;
      end
      if (n == 7) check("R2", n, pulse_out, 1'b0);
    end
    // R2: triggers ignored while disabled
    for (int k = 0; k < 3; k++) begin
      trig_in = 1'b1;
      for (int n = 0; n < 12; n++) begin
        @(posedge clk);
        @(negedge clk);
        if (n == 1) trig_in = 1'b0;
        check("R2", n, pulse_out, 1'b0);
      end
    end
    enable = 1'b1;
    repeat (3) @(negedge clk);

    // R4 R5 R6 R8: random set-points, stop-points, hold times and retriggers
    for (int t = 0; t < 60; t++) begin
      int a, c, h, d;
      bit re;
      a  = int'($urandom_range(0, 12));
      c  = int'($urandom_range(0, 12));
      h  = int'($urandom_range(1, 3));
      re = ($urandom_range(0, 3) == 0);
      d  = int'($urandom_range(6, 2 + 2*c + 6));
      fire(re ? "R8" : "R4", a, c, h, re, d);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule